// File: doc/BRIEF.md
# Programmable AND-OR Product-Term Array

This block is a purely combinational sum-of-products engine whose function is set by a flat configuration bit matrix. Ten dedicated inputs and eight feedback signals each supply a true and an inverted copy, which gives 36 array lines. Every product term is a wide AND over the lines that the configuration connects to it. There are 74 terms, and each has a fixed role. Sixty-four of them are OR-ed in fixed groups of eight to form eight sum outputs. Eight more are output-enable terms, one per output. The last two are a global preset term and a global clear term.

A configuration bit set to 1 connects a line to a term. An all-zero row leaves the term unconstrained, so it reads TRUE. A row that connects both polarities of one signal can never be satisfied, so it reads FALSE. The output registers, polarity selection and feedback multiplexing are expected to sit in the surrounding macrocells, which consume the sum, enable, preset and clear signals. All outputs follow the inputs and the configuration with no internal state.

Top module: `sop_array`

## Requirements
- R1: Array line 2k carries inPins[k] and line 2k+1 carries its inverse, for k = 0..9. Line 20+2j carries fbPins[j] and line 21+2j carries its inverse, for j = 0..7.
- R2: Configuration bit cfgBits[t*36 + l] set to 1 connects line l to term t. A bit of 0 leaves the line out of that term.
- R3: Each term is the AND of its connected lines. sumOut[g] is the OR of terms 8g through 8g+7.
- R4: A term whose 36 configuration bits are all 0 evaluates to 1.
- R5: A term that connects both the true and the inverted line of the same signal evaluates to 0, whatever the input values.
- R6: Term 64+i drives oeTerm[i] for i = 0..7. Term 72 drives presetTerm and term 73 drives clearTerm.
- R7: With the configuration fully erased (all bits 0), every output is 1. With every bit set to 1, every output is 0.
- R8: The outputs settle from the inputs and the configuration without any clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| inPins | input | 10 | Dedicated input signals |
| fbPins | input | 8 | Feedback signals from the I/O side |
| cfgBits | input | 2664 | Connection matrix, term-major, 36 bits per term |
| sumOut | output | 8 | OR of each group of eight summing terms |
| oeTerm | output | 8 | Per-output enable product terms |
| presetTerm | output | 1 | Global preset product term |
| clearTerm | output | 1 | Global clear product term |

## Verification
The embedded immediate assertions re-check four things on every evaluation. An erased row reads TRUE. A row holding both polarities of a signal reads FALSE. Each sum matches the OR of its group's terms. The enable, preset and clear strobes come from the correct term indices. Other properties can only be shown by the bench's sweeps. These are the exact mapping of each pin onto its true and inverted line, the term-major position of each configuration bit, and the term-by-term isolation of roles. The sweeps compare every output against an arithmetic model under one-line, one-term and sparse random configurations.

// File: rtl/sop_pkg.sv
package sop_pkg;
  localparam int NUM_IN        = 10;
  localparam int NUM_FB        = 8;
  localparam int NUM_OUT       = 8;
  localparam int TERMS_PER_OUT = 8;
  localparam int NUM_SIG       = NUM_IN + NUM_FB;
  localparam int NUM_LINES     = 2 * NUM_SIG;
  localparam int NUM_SUM_TERMS = NUM_OUT * TERMS_PER_OUT;
  localparam int NUM_TERMS     = NUM_SUM_TERMS + NUM_OUT + 2;
  localparam int CFG_W         = NUM_TERMS * NUM_LINES;

  // strobes handed from the role decoder to the outputs
  typedef struct packed {
    logic [NUM_OUT-1:0] oe;
    logic               preset;
    logic               clear;
  } ctrl_strobes_t;
endpackage

// File: rtl/sop_lines.sv
module sop_lines #(
  parameter int NUM_IN = 10,
  parameter int NUM_FB = 8,
  localparam int NUM_LINES = 2 * (NUM_IN + NUM_FB)
) (
  input  logic [NUM_IN-1:0]    inPins,
  input  logic [NUM_FB-1:0]    fbPins,
  output logic [NUM_LINES-1:0] lineVec
);
  for (genvar k = 0; k < NUM_IN; k++) begin : g_in
    assign lineVec[2*k]   = inPins[k];
    assign lineVec[2*k+1] = ~inPins[k];
  end
  for (genvar j = 0; j < NUM_FB; j++) begin : g_fb
    assign lineVec[2*NUM_IN+2*j]   = fbPins[j];
    assign lineVec[2*NUM_IN+2*j+1] = ~fbPins[j];
  end
endmodule

// File: rtl/sop_datapath.sv
module sop_datapath #(
  parameter int NUM_LINES     = 36,
  parameter int NUM_TERMS     = 74,
  parameter int NUM_OUT       = 8,
  parameter int TERMS_PER_OUT = 8,
  localparam int CFG_W        = NUM_TERMS * NUM_LINES
) (
  input  logic [NUM_LINES-1:0] lineVec,
  input  logic [CFG_W-1:0]     cfgBits,
  output logic [NUM_TERMS-1:0] termVec,
  output logic [NUM_OUT-1:0]   sumOut
);
  // a connected line must be high; an unconnected line is a don't-care
  for (genvar t = 0; t < NUM_TERMS; t++) begin : g_term
    assign termVec[t] = &(~cfgBits[t*NUM_LINES +: NUM_LINES] | lineVec);
  end
  for (genvar g = 0; g < NUM_OUT; g++) begin : g_sum
    assign sumOut[g] = |termVec[g*TERMS_PER_OUT +: TERMS_PER_OUT];
  end
endmodule

// File: rtl/sop_ctrl.sv
module sop_ctrl
  import sop_pkg::*;
(
  input  logic [NUM_OUT+1:0] ctrlTerms,
  output ctrl_strobes_t      strobes
);
  always_comb begin
    strobes.oe     = ctrlTerms[NUM_OUT-1:0];
    strobes.preset = ctrlTerms[NUM_OUT];
    strobes.clear  = ctrlTerms[NUM_OUT+1];
  end
endmodule

// File: rtl/sop_array.sv
module sop_array
  import sop_pkg::*;
(
  input  logic [NUM_IN-1:0]  inPins,
  input  logic [NUM_FB-1:0]  fbPins,
  input  logic [CFG_W-1:0]   cfgBits,
  output logic [NUM_OUT-1:0] sumOut,
  output logic [NUM_OUT-1:0] oeTerm,
  output logic               presetTerm,
  output logic               clearTerm
);
  logic [NUM_LINES-1:0] lineVec;
  logic [NUM_TERMS-1:0] termVec;
  ctrl_strobes_t        strobes;

  sop_lines #(.NUM_IN(NUM_IN), .NUM_FB(NUM_FB)) u_lines (
    .inPins(inPins), .fbPins(fbPins), .lineVec(lineVec)
  );

  sop_datapath #(
    .NUM_LINES(NUM_LINES), .NUM_TERMS(NUM_TERMS),
    .NUM_OUT(NUM_OUT), .TERMS_PER_OUT(TERMS_PER_OUT)
  ) u_dp (
    .lineVec(lineVec), .cfgBits(cfgBits), .termVec(termVec), .sumOut(sumOut)
  );

  sop_ctrl u_ctrl (
    .ctrlTerms(termVec[NUM_SUM_TERMS +: NUM_OUT+2]), .strobes(strobes)
  );

  assign oeTerm     = strobes.oe;
  assign presetTerm = strobes.preset;
  assign clearTerm  = strobes.clear;

  always_comb begin
    for (int t = 0; t < NUM_TERMS; t++) begin
      if (cfgBits[t*NUM_LINES +: NUM_LINES] == '0)
        assert_erased_true_R4: assert (termVec[t])
          else $error("erased term %0d not true", t);
      for (int k = 0; k < NUM_SIG; k++) begin
        if (cfgBits[t*NUM_LINES + 2*k] && cfgBits[t*NUM_LINES + 2*k + 1])
          assert_contradiction_false_R5: assert (!termVec[t])
            else $error("term %0d with both polarities of signal %0d is true", t, k);
      end
    end
    for (int g = 0; g < NUM_OUT; g++) begin
      assert_sum_group_R3: assert (sumOut[g] == |termVec[g*TERMS_PER_OUT +: TERMS_PER_OUT])
        else $error("sum %0d disagrees with its group", g);
    end
    assert_role_map_R6: assert (oeTerm == termVec[NUM_SUM_TERMS +: NUM_OUT]
                                && presetTerm == termVec[NUM_SUM_TERMS+NUM_OUT]
                                && clearTerm == termVec[NUM_SUM_TERMS+NUM_OUT+1])
      else $error("control term roles misrouted");
  end
endmodule

// File: tb/sop_array_tb.sv
module sop_array_tb;
  import sop_pkg::*;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  always #2 clk = ~clk;

  logic [NUM_IN-1:0]  inPins;
  logic [NUM_FB-1:0]  fbPins;
  logic [CFG_W-1:0]   cfgBits;
  logic [NUM_OUT-1:0] sumOut, oeTerm;
  logic               presetTerm, clearTerm;

  int nChecks = 0;
  int nFails  = 0;
  bit doneFlag = 1'b0;

  sop_array u_dut (
    .inPins(inPins), .fbPins(fbPins), .cfgBits(cfgBits),
    .sumOut(sumOut), .oeTerm(oeTerm), .presetTerm(presetTerm), .clearTerm(clearTerm)
  );

  // expected {clear, preset, oe[7:0], sum[7:0]} from the requirements
  function automatic logic [17:0] refModel(logic [CFG_W-1:0] c, logic [NUM_IN-1:0] a,
                                           logic [NUM_FB-1:0] f);
    logic [NUM_LINES-1:0] ln;
    logic [NUM_TERMS-1:0] tv;
    logic [NUM_OUT-1:0]   s;
    for (int k = 0; k < NUM_IN; k++) begin ln[2*k] = a[k]; ln[2*k+1] = !a[k]; end
    for (int j = 0; j < NUM_FB; j++) begin ln[20+2*j] = f[j]; ln[21+2*j] = !f[j]; end
    for (int t = 0; t < NUM_TERMS; t++) begin
      tv[t] = 1'b1;
      for (int l = 0; l < NUM_LINES; l++)
        if (c[t*NUM_LINES+l] && !ln[l]) tv[t] = 1'b0;
    end
    for (int g = 0; g < NUM_OUT; g++) begin
      s[g] = 1'b0;
      for (int m = 0; m < TERMS_PER_OUT; m++) s[g] = s[g] | tv[g*TERMS_PER_OUT+m];
    end
    return {tv[73], tv[72], tv[71:64], s};
  endfunction

  task automatic check(string req, logic [17:0] exp);
    logic [17:0] act;
    @(negedge clk);
    act = {clearTerm, presetTerm, oeTerm, sumOut};
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: actual %05h expected %05h", req, act, exp);
    end
  endtask

  initial begin
    #400000;
    if (!doneFlag) begin
      nChecks++; nFails++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
      $finish;
    end
  end

  initial begin
    inPins = '0; fbPins = '0; cfgBits = '0;
    repeat (3) @(posedge clk);
    rstN = 1'b1;

    // R7 / R4: erased array, every output high for several patterns
    check("R7 erased reset state", 18'h3FFFF);
    inPins = 10'h2A5; fbPins = 8'hC3;
    check("R7 erased", 18'h3FFFF);
    inPins = '1; fbPins = '1;
    check("R4 erased term true", 18'h3FFFF);

    // R7 / R5: fully programmed, every term contradicts itself
    cfgBits = '1;
    inPins = '0; fbPins = '0;
    check("R7 all connected", 18'h00000);
    inPins = 10'h155; fbPins = 8'hAA;
    check("R5 contradiction false", 18'h00000);

    // R5: one term with only signal 3 both polarities, rest erased
    cfgBits = '0;
    cfgBits[73*NUM_LINES + 6] = 1'b1;
    cfgBits[73*NUM_LINES + 7] = 1'b1;
    for (int v = 0; v < 2; v++) begin
      inPins = v[0] ? '1 : '0;
      check("R5 clear term single contradiction", 18'h1FFFF);
    end

    // R1 / R2: every term connects only line l; outputs follow that line
    for (int l = 0; l < NUM_LINES; l++) begin
      cfgBits = '0;
      for (int t = 0; t < NUM_TERMS; t++) cfgBits[t*NUM_LINES + l] = 1'b1;
      for (int v = 0; v < 2; v++) begin
        inPins = '0; fbPins = '0;
        if (l < 20) inPins[l/2] = v[0]; else fbPins[(l-20)/2] = v[0];
        // true line equals v, inverted line equals !v
        check("R1 line mapping", ((l % 2 == 0) == (v == 1)) ? 18'h3FFFF : 18'h00000);
      end
    end

    // R6 / R2 / R3: only term t erased (true), all others contradicting
    inPins = 10'h0F0; fbPins = 8'h3C;
    for (int t = 0; t < NUM_TERMS; t++) begin
      logic [17:0] e;
      cfgBits = '1;
      cfgBits[t*NUM_LINES +: NUM_LINES] = '0;
      e = '0;
      if (t < 64) e[t/8] = 1'b1; else e[t-56] = 1'b1;
      check("R6 term role isolation", e);
    end

    // R3: two connected lines AND together inside term 5 of group 0
    cfgBits = '1;
    cfgBits[5*NUM_LINES +: NUM_LINES] = '0;
    cfgBits[5*NUM_LINES + 0] = 1'b1;   // inPins[0] true
    cfgBits[5*NUM_LINES + 21] = 1'b1;  // fbPins[0] inverted
    for (int v = 0; v < 4; v++) begin
      inPins = '0; fbPins = '0;
      inPins[0] = v[0]; fbPins[0] = v[1];
      check("R3 and of connected lines", (v == 1) ? 18'h00001 : 18'h00000);
    end

    // R3 / R2: sparse random configurations against the model
    for (int n = 0; n < 400; n++) begin
      cfgBits = '0;
      for (int t = 0; t < NUM_TERMS; t++) begin
        int cnt = $urandom_range(0, 3);
        for (int c = 0; c < cnt; c++) cfgBits[t*NUM_LINES + $urandom_range(0, NUM_LINES-1)] = 1'b1;
      end
      inPins = 10'($urandom); fbPins = 8'($urandom);
      check("R3 random sum of products", refModel(cfgBits, inPins, fbPins));
    end

    // R8: change inputs mid-cycle, output settles without a clock edge
    @(posedge clk);
    #1;
    inPins = 10'h3FF; fbPins = 8'h00;
    #0.5;
    nChecks++;
    if ({clearTerm, presetTerm, oeTerm, sumOut} !== refModel(cfgBits, inPins, fbPins)) begin
      nFails++;
      $display("FAIL R8: actual %05h expected %05h",
               {clearTerm, presetTerm, oeTerm, sumOut}, refModel(cfgBits, inPins, fbPins));
    end

    doneFlag = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end
endmodule